// File: doc/BRIEF.md
# Pulse-Position Header Router

This block forwards serial packets to any subset of three output ports. A packet arrives one bit per clock on a single data input. A strobe marks its first bit. The first five bits form the header: a marker bit that must be set, then a four-bit destination address sent most significant bit first. The rest of the packet is payload.

The whole packet is written into an internal store. Only after the store is full does route resolution begin. The address does not index a table. Instead, a single pulse is sent through four delay stages with binary weights, so it comes out in the time slot whose number equals the address. A slot counter walks slots 0 to 15. In each slot the pulse is ANDed with three per-port slot patterns, and every port that sees a coincidence is added to a port mask. When slot 15 ends, the mask and a unicast, multicast or broadcast indication are latched. The stored packet, header included, then streams out on every enabled port at once. An address that matches no pattern is dropped. A frame whose marker bit is clear is rejected and flagged.

Top module: `pp_router`

## Requirements
- R1: While reset is active and right after it, tx_valid, tx_data, route_mask, cast_kind, busy and hdr_err are all zero.
- R2: A frame is PKT_LEN bits, one per clock. The edge where frame_start is high takes bit 0 (the marker, which must be 1). The next four edges take address bits 3, 2, 1 and 0 in that order, and payload bits follow.
- R3: route_mask bit 0, 1 and 2 select output ports 1, 2 and 3. With the default patterns, port 1 is reached by addresses 0, 2, 6, 9, 10, 12 and 14. Port 2 is reached by 1, 4, 8, 13 and 14. Port 3 is reached by 1, 5, 7, 10, 11, 14 and 15. Address 3 reaches no port.
- R4: cast_kind is 0 for no port, 1 for one port, 2 for two ports and 3 for all three.
- R5: Count the frame_start edge as edge 0. The mask is latched at edge PKT_LEN+15, and the first output beat is registered at edge PKT_LEN+16.
- R6: Forwarding lasts PKT_LEN beats and reproduces the stored frame bit for bit, header included. Every enabled port carries the same bit with tx_valid set. Disabled ports keep tx_valid and tx_data at 0.
- R7: An address with no match produces no output beat and latches route_mask 0 and cast_kind 0. busy clears at edge PKT_LEN+16.
- R8: If frame_start comes with a 0 bit while the block is idle, the frame is discarded. hdr_err is high for the one cycle after that edge, busy stays low, and nothing is forwarded.
- R9: busy is high from the accepted frame_start edge until the last output beat has been removed. A frame_start seen while busy is high is ignored and yields no packet.
- R10: route_mask and cast_kind keep their latched values until the next packet latches new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | High with the first bit of a frame |
| rx_bit | input | 1 | Serial packet data |
| busy | output | 1 | Packet in progress; new frames ignored |
| hdr_err | output | 1 | One-cycle pulse for a frame with a missing marker |
| tx_valid | output | 3 | Per-port beat valid |
| tx_data | output | 3 | Per-port serial output data |
| route_mask | output | 3 | Latched port mask of the last resolved packet |
| cast_kind | output | 2 | Latched delivery kind (none/uni/multi/broad) |

## Verification
Outputs are sampled on the falling edge, and every expected time is counted from the falling edge on which frame_start is driven. hdr_err is due one cycle after that edge. The latched mask and kind are due PKT_LEN+16 cycles after it, and the first forwarded beat is due PKT_LEN+17 cycles after it. When a forwarding packet is sent, the driver stores that due cycle in the scoreboard. The monitor then compares it with the cycle count at the first beat it sees. For dropped packets, the main flow waits for the exact latch cycle before reading the mask, and checks busy one cycle later.

// File: rtl/pp_router_pkg.sv
package pp_router_pkg;
  localparam int ADDR_W  = 4;
  localparam int NSLOT   = 1 << ADDR_W;
  localparam int NPORT   = 3;
  localparam int HDR_LEN = 1 + ADDR_W;

  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_SWEEP, ST_SEND} rt_state_e;
  typedef enum logic [1:0] {CAST_NONE, CAST_UNI, CAST_MULTI, CAST_BCAST} cast_e;

  function automatic logic [1:0] cast_of(input logic [NPORT-1:0] m);
    int n;
    n = $countones(m);
    if (n == 0)          return CAST_NONE;
    else if (n == 1)     return CAST_UNI;
    else if (n == NPORT) return CAST_BCAST;
    else                 return CAST_MULTI;
  endfunction
endpackage

// File: rtl/pp_delay_stage.sv
module pp_delay_stage #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  input  logic use_delay,
  output logic pulse_out
);
  logic [DEPTH-1:0] sr_q, sr_d;

  generate
    if (DEPTH == 1) begin : g_one
      always_comb sr_d = pulse_in;
    end else begin : g_many
      always_comb sr_d = {sr_q[DEPTH-2:0], pulse_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign pulse_out = use_delay ? sr_q[DEPTH-1] : pulse_in;
endmodule

// File: rtl/pp_slot_match.sv
module pp_slot_match
  import pp_router_pkg::*;
#(
  parameter logic [NPORT*NSLOT-1:0] MAP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_en,
  input  logic              latch_en,
  input  logic [ADDR_W-1:0] slot,
  input  logic              addr_pulse,
  output logic [NPORT-1:0]  route_mask,
  output logic [1:0]        cast_kind
);
  logic [NPORT-1:0] coin, hit_q, hit_d, mask_d;
  logic [1:0]       kind_d;

  always_comb begin
    for (int p = 0; p < NPORT; p++)
      coin[p] = addr_pulse & MAP[p*NSLOT + int'(slot)];
    hit_d  = hit_q;
    mask_d = route_mask;
    kind_d = cast_kind;
    if (latch_en) begin
      mask_d = hit_q | coin;
      kind_d = cast_of(hit_q | coin);
      hit_d  = '0;
    end else if (sweep_en) begin
      hit_d = hit_q | coin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q      <= '0;
      route_mask <= '0;
      cast_kind  <= '0;
    end else begin
      hit_q      <= hit_d;
      route_mask <= mask_d;
      cast_kind  <= kind_d;
    end
  end
endmodule

// File: rtl/pp_pkt_store.sv
module pp_pkt_store #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  output logic rd_bit
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign rd_bit = mem[rd_ptr];
endmodule

// File: rtl/pp_router.sv
module pp_router
  import pp_router_pkg::*;
#(
  parameter int PKT_LEN = 16,
  parameter logic [NPORT*NSLOT-1:0] ROUTE_MAP = {16'hCCA2, 16'h6112, 16'h5645}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             rx_bit,
  output logic             busy,
  output logic             hdr_err,
  output logic [NPORT-1:0] tx_valid,
  output logic [NPORT-1:0] tx_data,
  output logic [NPORT-1:0] route_mask,
  output logic [1:0]       cast_kind
);
  localparam int CNT_W = $clog2(PKT_LEN > NSLOT ? PKT_LEN : NSLOT);
  localparam logic [CNT_W-1:0] PKT_LAST  = CNT_W'(PKT_LEN - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(NSLOT - 1);

  // synchronous release of the asynchronous reset
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  rt_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              err_d;
  logic [NPORT-1:0]  tx_v_d, tx_d_d;
  logic              wr_en, rd_en, rd_bit, tx_any;
  logic              sweep_en, latch_en, inject, addr_pulse;
  logic [ADDR_W:0]   chain;

  assign tx_any   = |tx_valid;
  assign busy     = (st_q != ST_IDLE) | tx_any;
  assign sweep_en = (st_q == ST_SWEEP);
  assign latch_en = sweep_en && (cnt_q == SLOT_LAST);
  assign inject   = sweep_en && (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    err_d  = 1'b0;
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    tx_v_d = '0;
    tx_d_d = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (frame_start && !tx_any) begin
          if (rx_bit) begin
            st_d  = ST_RECV;
            cnt_d = CNT_W'(1);
            wr_en = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RECV: begin
        wr_en = 1'b1;
        if (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(ADDR_W))
          addr_d = {addr_q[ADDR_W-2:0], rx_bit};
        if (cnt_q == PKT_LAST) begin
          st_d  = ST_SWEEP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SWEEP: begin
        if (cnt_q == SLOT_LAST) begin
          st_d  = ST_SEND;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SEND: begin
        if (route_mask == '0) begin
          st_d = ST_IDLE;
        end else begin
          rd_en  = 1'b1;
          tx_v_d = route_mask;
          tx_d_d = {NPORT{rd_bit}} & route_mask;
          if (cnt_q == PKT_LAST) st_d = ST_IDLE;
          else                   cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      addr_q   <= '0;
      hdr_err  <= 1'b0;
      tx_valid <= '0;
      tx_data  <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
      hdr_err  <= err_d;
      tx_valid <= tx_v_d;
      tx_data  <= tx_d_d;
    end
  end

  // binary-weighted delay line: stage i adds 2**i slots when address bit i is set
  assign chain[0] = inject;
  for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_stage
    pp_delay_stage #(.DEPTH(1 << gi)) u_stage (
      .clk       (clk),
      .rst_n     (rst_i),
      .pulse_in  (chain[gi]),
      .use_delay (addr_q[gi]),
      .pulse_out (chain[gi+1])
    );
  end
  assign addr_pulse = chain[ADDR_W];

  pp_slot_match #(.MAP(ROUTE_MAP)) u_match (
    .clk        (clk),
    .rst_n      (rst_i),
    .sweep_en   (sweep_en),
    .latch_en   (latch_en),
    .slot       (cnt_q[ADDR_W-1:0]),
    .addr_pulse (addr_pulse),
    .route_mask (route_mask),
    .cast_kind  (cast_kind)
  );

  pp_pkt_store #(.DEPTH(PKT_LEN)) u_store (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr_en  (wr_en),
    .wr_bit (rx_bit),
    .rd_en  (rd_en),
    .rd_bit (rd_bit)
  );
endmodule

// File: rtl/pp_router_chk.sv
module pp_router_chk
  import pp_router_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             rx_bit,
  input logic             busy,
  input logic             hdr_err,
  input logic [NPORT-1:0] tx_valid,
  input logic [NPORT-1:0] route_mask,
  input logic [1:0]       cast_kind
);
  // R6: beats appear only on the latched ports
  a_r6_valid_is_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_valid) |-> (tx_valid == route_mask));

  // R7: an empty mask never forwards
  a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mask == '0) |-> (tx_valid == '0));

  // R4: an empty mask is reported as no delivery
  a_r4_none_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mask == '0) |-> (cast_kind == 2'd0));

  // R4: a single port is reported as unicast
  a_r4_uni_kind: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(route_mask) == 1) |-> (cast_kind == 2'd1));

  // R8: an error pulse follows a start with a clear marker
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> ($past(frame_start && !rx_bit) && !busy));

  // R9: output beats only while busy
  a_r9_busy_covers_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_valid) |-> busy);

  // R10: latched mask holds while idle
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(route_mask));
endmodule

bind pp_router pp_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .rx_bit      (rx_bit),
  .busy        (busy),
  .hdr_err     (hdr_err),
  .tx_valid    (tx_valid),
  .route_mask  (route_mask),
  .cast_kind   (cast_kind)
);

// File: tb/test_pp_router.sv
module test_pp_router;
  localparam int L  = 16;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n, frame_start, rx_bit;
  logic          busy, hdr_err;
  logic [NP-1:0] tx_valid, tx_data, route_mask;
  logic [1:0]    cast_kind;

  always #5 clk = ~clk;

  pp_router #(.PKT_LEN(L)) i_pp_router (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_bit(rx_bit),
    .busy(busy), .hdr_err(hdr_err), .tx_valid(tx_valid), .tx_data(tx_data),
    .route_mask(route_mask), .cast_kind(cast_kind)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, pk_exp = 0, pk_seen = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected routing from the requirement (R3)
  function automatic logic [NP-1:0] exp_mask(input logic [3:0] a);
    logic [NP-1:0] m;
    m[0] = a inside {4'd0, 4'd2, 4'd6, 4'd9, 4'd10, 4'd12, 4'd14};
    m[1] = a inside {4'd1, 4'd4, 4'd8, 4'd13, 4'd14};
    m[2] = a inside {4'd1, 4'd5, 4'd7, 4'd10, 4'd11, 4'd14, 4'd15};
    return m;
  endfunction

  function automatic logic [1:0] exp_kind(input logic [NP-1:0] m);
    return 2'($countones(m));
  endfunction

  typedef struct {
    int            due;
    logic [NP-1:0] mask;
    logic [1:0]    kind;
    logic [L-1:0]  bits;
  } exp_t;
  exp_t sb[$];

  // driver: called on a falling edge, returns on a falling edge L cycles later
  task automatic send(input logic [3:0] a, input logic [L-6:0] pay);
    logic [L-1:0] b;
    exp_t e;
    b[0] = 1'b1;
    b[1] = a[3]; b[2] = a[2]; b[3] = a[1]; b[4] = a[0];
    for (int i = 0; i < L - 5; i++) b[5+i] = pay[i];
    e.due  = cyc + L + 17;
    e.mask = exp_mask(a);
    e.kind = exp_kind(e.mask);
    e.bits = b;
    if (e.mask != '0) begin
      sb.push_back(e);
      pk_exp++;
    end
    for (int i = 0; i < L; i++) begin
      frame_start = (i == 0);
      rx_bit      = b[i];
      @(negedge clk);
    end
    frame_start = 1'b0;
    rx_bit      = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  exp_t cur;
  int   beat = 0;
  bit   bad  = 1'b0;
  bit   have = 1'b0;
  always @(negedge clk) begin
    if (rst_n && tx_valid != '0) begin
      if (beat == 0) begin
        pk_seen++;
        bad = 1'b0;
        if (sb.size() == 0) begin
          have = 1'b0;
          chk(1'b0, "R9", "unexpected packet", int'(tx_valid), 0);
        end else begin
          have = 1'b1;
          cur  = sb.pop_front();
          chk(cyc == cur.due, "R5", "first beat cycle", cyc, cur.due);
          chk(tx_valid == cur.mask, "R3", "port mask", int'(tx_valid), int'(cur.mask));
          chk(cast_kind == cur.kind, "R4", "cast kind", int'(cast_kind), int'(cur.kind));
        end
      end
      if (have && (tx_valid != cur.mask ||
                   tx_data != ({NP{cur.bits[beat]}} & cur.mask))) bad = 1'b1;
      beat++;
      if (beat == L) begin
        if (have) chk(!bad, "R6", "forwarded frame content", int'(bad), 0);
        beat = 0;
      end
    end else if (rst_n && beat != 0) begin
      chk(1'b0, "R6", "short packet beats", beat, L);
      beat = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; frame_start = 1'b0; rx_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk({tx_valid, tx_data, route_mask, cast_kind, busy, hdr_err} == '0,
        "R1", "outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({tx_valid, route_mask, cast_kind, busy, hdr_err} == '0,
        "R1", "outputs after reset", int'(route_mask), 0);

    // R2/R3/R5/R6 across several addresses; 1 versus 8 exercises MSB-first order (R2)
    send(4'd10, 11'h5A3); wait_idle();
    chk(route_mask == 3'b101 && cast_kind == 2'd2, "R10", "mask held after idle",
        int'(route_mask), 5);
    send(4'd14, 11'h0F0); wait_idle();
    send(4'd5,  11'h7FF); wait_idle();
    send(4'd1,  11'h001); wait_idle();
    send(4'd8,  11'h400); wait_idle();
    send(4'd0,  11'h2AA); wait_idle();
    send(4'd15, 11'h155); wait_idle();
    send(4'd13, 11'h333); wait_idle();

    // R7 drop on address 3
    c0 = cyc;
    send(4'd3, 11'h6C9);
    while (cyc < c0 + L + 16) @(negedge clk);
    chk(route_mask == '0, "R7", "dropped mask", int'(route_mask), 0);
    chk(cast_kind == 2'd0, "R7", "dropped kind", int'(cast_kind), 0);
    chk(busy == 1'b1, "R9", "busy before drop ends", int'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R7", "busy clear after drop", int'(busy), 0);
    repeat (L) @(negedge clk);
    chk(tx_valid == '0, "R7", "no beats for drop", int'(tx_valid), 0);

    // R8 malformed frame
    frame_start = 1'b1; rx_bit = 1'b0;
    @(negedge clk);
    chk(hdr_err == 1'b1, "R8", "error pulse", int'(hdr_err), 1);
    chk(busy == 1'b0, "R8", "busy stays low", int'(busy), 0);
    frame_start = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
    chk(hdr_err == 1'b0, "R8", "error pulse width", int'(hdr_err), 0);
    repeat (L + 20) @(negedge clk);
    rx_bit = 1'b0;
    chk(busy == 1'b0 && tx_valid == '0, "R8", "malformed not forwarded", int'(busy), 0);

    // R9 start while busy is ignored
    send(4'd12, 11'h1E7);
    chk(busy == 1'b1, "R9", "busy during sweep", int'(busy), 1);
    frame_start = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    rx_bit = 1'b0;
    wait_idle();
    send(4'd7, 11'h0C3); wait_idle();
    chk(route_mask == 3'b100 && cast_kind == 2'd1, "R10", "mask held", int'(route_mask), 4);
    chk(pk_seen == pk_exp, "R9", "packet count", pk_seen, pk_exp);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule